// File: doc/BRIEF.md
# Channelized Port Time-Slot Mapper

The mapper sits on the receive side of a serial line port. It takes one data bit per clock, together with a frame sync that marks the first clock of each frame. It counts bit positions inside the frame and collects eight bits into each 64 kbit/s time slot. Every completed slot is emitted with a strobe, its slot index and the HDLC channel number that owns it. The next stage can then hand each byte to the right channel without keeping its own frame map.

Ownership comes from two configuration inputs, a first channel number and a channel count. The mapper divides the slots of the frame into equal, contiguous shares. The first channel owns slot 0, and each following channel starts right after the previous share ends. Any slots left over by the division belong to the last channel. Four frame formats are supported: 24 slots in a 193-clock frame whose first clock is a framing bit, and 32, 64 or 128 slots with 8 clocks per slot. In the unchannelized mode every eight bits form a byte for a single channel and no sync is needed.

Top module: `time_slot_mapper`

## Requirements
- R1: The mode input selects the frame: 0 gives 24 slots in 193 clocks, 1 gives 32 slots in 256 clocks, 2 gives 64 slots in 512 clocks, 3 gives 128 slots in 1024 clocks, and 4 selects unchannelized operation. Without a new sync, the bit position wraps to 0 after the last clock of the frame.
- R2: In mode 0, the clock at position 0 of the frame is a framing bit and belongs to no slot. Slot k takes positions 8k+1 to 8k+8.
- R3: Bits are assembled first-received-first, so the first bit of a slot lands in bit 7 of `byte_data`. `byte_valid` is high for exactly one cycle, in the cycle after the clock that carried the last bit of the slot.
- R4: With S slots and a channel count C, where 1 <= C <= S, slot s belongs to channel `first_chan + s / (S / C)`, modulo 2^CHAN_W, while `s / (S / C)` is below C.
- R5: Slots from C*(S/C) up to S-1 belong to the last channel, `first_chan + C - 1`.
- R6: A channel count of 0 marks every slot idle, and `byte_valid` stays low.
- R7: In mode 4, every eight clocks after reset produce one byte with slot index 0 and channel `first_chan`. The sync input has no effect in this mode.
- R8: `cfg_err` is high when the mode is 5 to 7, when the mode is 4 and the count is above 1, or when a channelized count exceeds the slot count of the mode. While `cfg_err` is high, no strobe is produced.
- R9: In channelized modes, no strobe is produced before the first sync after reset.
- R10: A sync forces the current clock to frame position 0 whenever it arrives, including in the middle of a frame.
- R11: During and right after reset, `byte_valid`, `byte_data`, `slot_idx` and `chan_id` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 3 | Frame format select (0..4, see R1) |
| first_chan | input | CHAN_W | Channel number that owns slot 0 |
| chan_count | input | SLOT_W+1 | Number of channels sharing the port |
| sync | input | 1 | High on the first clock of a frame |
| din | input | 1 | Serial data bit |
| cfg_err | output | 1 | Configuration is invalid |
| byte_valid | output | 1 | One-cycle strobe for a completed slot |
| byte_data | output | 8 | Slot byte, first bit received in bit 7 |
| slot_idx | output | SLOT_W | Index of the completed slot |
| chan_id | output | CHAN_W | Channel that owns the slot |

## Verification
A bit counter that drifts by one clock shows up at the ports within one slot, either as a strobe one cycle early or late or as a byte shifted by one bit. A wrong share counter shows up at the first share boundary as the wrong `chan_id`, at most S/C slots into the frame. For that reason, every configuration is run over whole frames with random data and a cycle-exact expected strobe, and nothing is sampled at a handful of points. The runs cover the leftover-slot cases, the idle case, the error cases and a sync that lands in the middle of a frame.

// File: rtl/tsm_pkg.sv
package tsm_pkg;

   localparam int BITS_PER_SLOT = 8;

   typedef enum logic [2:0] {
      MODE_T1   = 3'd0,
      MODE_E1   = 3'd1,
      MODE_4M   = 3'd2,
      MODE_8M   = 3'd3,
      MODE_UNCH = 3'd4
   } tsm_mode_e;

   // number of slots in one frame, 0 for unchannelized or invalid
   function automatic int slots_of(input logic [2:0] m);
      case (m)
         MODE_T1: return 24;
         MODE_E1: return 32;
         MODE_4M: return 64;
         MODE_8M: return 128;
         default: return 0;
      endcase
   endfunction

   // clocks between syncs; unchannelized wraps every byte
   function automatic int frame_len_of(input logic [2:0] m);
      case (m)
         MODE_T1: return 193;
         MODE_E1: return 256;
         MODE_4M: return 512;
         MODE_8M: return 1024;
         default: return BITS_PER_SLOT;
      endcase
   endfunction

endpackage

// File: rtl/tsm_frame_counter.sv
module tsm_frame_counter #(
   parameter int POS_W  = 11,
   parameter int SLOT_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              unch,
   input  logic              framing_bit,
   input  logic [POS_W-1:0]  frame_len,
   input  logic              sync,
   output logic              slot_end,
   output logic [SLOT_W-1:0] slot_num
);

   logic [POS_W-1:0] pos_q, pos_d, cur_pos, data_off;
   logic             aligned_q, live, is_framing;

   always_comb begin
      cur_pos    = (sync && !unch) ? '0 : pos_q;
      live       = unch || aligned_q || sync;
      is_framing = framing_bit && (cur_pos == '0);
      data_off   = framing_bit ? cur_pos - POS_W'(1) : cur_pos;
      slot_end   = live && !is_framing && (data_off[2:0] == 3'd7);
      slot_num   = unch ? '0 : data_off[3 +: SLOT_W];
      pos_d      = (cur_pos == frame_len - POS_W'(1)) ? '0 : cur_pos + POS_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_q     <= '0;
         aligned_q <= 1'b0;
      end else begin
         pos_q     <= pos_d;
         aligned_q <= aligned_q | (sync & ~unch);
      end
   end

   // R1
   pos_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pos_q < frame_len);

   // R9
   no_slot_unaligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!unch && !aligned_q && !sync) |-> !slot_end);

endmodule

// File: rtl/tsm_share_walker.sv
module tsm_share_walker #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             restart,
   input  logic [CNT_W-1:0] slots_per,
   input  logic [CNT_W-1:0] chan_count,
   output logic [CNT_W-1:0] chan_off
);

   logic [CNT_W-1:0] share_q, ch_q, cur_share, cur_ch;
   logic             advance;

   always_comb begin
      cur_share = restart ? '0 : share_q;
      cur_ch    = restart ? '0 : ch_q;
      advance   = (cur_share == slots_per - CNT_W'(1)) &&
                  (cur_ch != chan_count - CNT_W'(1)) && (chan_count != '0);
      chan_off  = cur_ch;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         share_q <= '0;
         ch_q    <= '0;
      end else if (step) begin
         if (advance) begin
            share_q <= '0;
            ch_q    <= cur_ch + CNT_W'(1);
         end else begin
            share_q <= (cur_share == '1) ? cur_share : cur_share + CNT_W'(1);
            ch_q    <= cur_ch;
         end
      end
   end

   // R4
   chan_off_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_count != '0) |-> (ch_q < chan_count));

endmodule

// File: rtl/time_slot_mapper.sv
module time_slot_mapper
   import tsm_pkg::*;
#(
   parameter int MAX_SLOTS = 128,
   parameter int CHAN_W    = 8,
   localparam int SLOT_W   = $clog2(MAX_SLOTS),
   localparam int CNT_W    = SLOT_W + 1,
   localparam int POS_W    = $clog2(MAX_SLOTS * BITS_PER_SLOT) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        mode,
   input  logic [CHAN_W-1:0] first_chan,
   input  logic [CNT_W-1:0]  chan_count,
   input  logic              sync,
   input  logic              din,
   output logic              cfg_err,
   output logic              byte_valid,
   output logic [7:0]        byte_data,
   output logic [SLOT_W-1:0] slot_idx,
   output logic [CHAN_W-1:0] chan_id
);

   if (MAX_SLOTS < 24) begin : g_bad_depth
      $error("MAX_SLOTS must cover the 24-slot frame");
   end
   if ((MAX_SLOTS & (MAX_SLOTS - 1)) != 0) begin : g_bad_pow2
      $error("MAX_SLOTS must be a power of two");
   end
   if (CHAN_W < CNT_W) begin : g_bad_chan
      $error("CHAN_W too narrow for the channel count");
   end

   logic              unch, framing_bit, slot_end, emit;
   logic [CNT_W-1:0]  nslots, slots_per, chan_off;
   logic [POS_W-1:0]  frame_len;
   logic [SLOT_W-1:0] slot_num;
   logic [6:0]        shift_q;

   always_comb begin
      unch        = (mode == MODE_UNCH);
      framing_bit = (mode == MODE_T1);
      nslots      = CNT_W'(slots_of(mode));
      frame_len   = POS_W'(frame_len_of(mode));
      slots_per   = (chan_count == '0 || unch) ? '0 : nslots / chan_count;
      cfg_err     = (mode > MODE_UNCH) ||
                    (unch && chan_count > CNT_W'(1)) ||
                    (!unch && chan_count > nslots) ||
                    (32'(slots_of(mode)) > MAX_SLOTS);
      emit        = slot_end && !cfg_err && (chan_count != '0);
   end

   tsm_frame_counter #(.POS_W(POS_W), .SLOT_W(SLOT_W)) counter_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .unch        (unch),
      .framing_bit (framing_bit),
      .frame_len   (frame_len),
      .sync        (sync),
      .slot_end    (slot_end),
      .slot_num    (slot_num)
   );

   tsm_share_walker #(.CNT_W(CNT_W)) walker_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .step       (slot_end),
      .restart    (slot_num == '0),
      .slots_per  (slots_per),
      .chan_count (chan_count),
      .chan_off   (chan_off)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shift_q    <= '0;
         byte_valid <= 1'b0;
         byte_data  <= '0;
         slot_idx   <= '0;
         chan_id    <= '0;
      end else begin
         shift_q    <= {shift_q[5:0], din};
         byte_valid <= emit;
         if (emit) begin
            byte_data <= {shift_q, din};
            slot_idx  <= slot_num;
            chan_id   <= first_chan + (unch ? '0 : CHAN_W'(chan_off));
         end
      end
   end

   // R8
   no_strobe_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |=> !byte_valid);

   // R6
   idle_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_count == '0) |=> !byte_valid);

   // R4
   chan_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid |-> (CHAN_W'(chan_id - first_chan) < CHAN_W'(chan_count)));

   // R1
   slot_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid && !unch) |-> (CNT_W'(slot_idx) < nslots));

   // R7
   unch_slot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid && unch) |-> (slot_idx == '0 && chan_id == first_chan));

   // R3
   single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid |=> !byte_valid);

endmodule

// File: tb/time_slot_mapper_tb_top.sv
module time_slot_mapper_tb_top;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] mode = 3'd0;
   logic [7:0] first_chan = 8'd0;
   logic [7:0] chan_count = 8'd0;
   logic       sync = 1'b0;
   logic       din = 1'b0;
   logic       cfg_err, byte_valid;
   logic [7:0] byte_data;
   logic [6:0] slot_idx;
   logic [7:0] chan_id;

   always #(CLK_PERIOD/2) clk = ~clk;

   time_slot_mapper dut_i (
      .clk(clk), .rst_n(rst_n), .mode(mode), .first_chan(first_chan),
      .chan_count(chan_count), .sync(sync), .din(din), .cfg_err(cfg_err),
      .byte_valid(byte_valid), .byte_data(byte_data), .slot_idx(slot_idx),
      .chan_id(chan_id)
   );

   int checks = 0;
   int fails  = 0;

   // model state
   int   m_slots, m_len, m_first, m_count;
   bit   m_unch, m_t1, m_err, m_aligned;
   int   m_pos;
   logic [7:0] m_shift;
   bit   exp_v;
   int   exp_data, exp_slot, exp_chan;
   string exp_req, idle_req;
   logic [15:0] lfsr = 16'hACE1;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic bit next_bit();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      return lfsr[0];
   endfunction

   // compare previous expectation, then drive one clock of stimulus
   task automatic step(input bit s, input bit d);
      int cur, off, slot, sp, idx;
      bit live, framing;
      if (exp_v || byte_valid) begin
         chk(byte_valid == exp_v, exp_v ? exp_req : idle_req, "strobe",
             int'(byte_valid), int'(exp_v));
         if (exp_v && byte_valid) begin
            chk(byte_data == exp_data[7:0], "R3", "data", byte_data, exp_data);
            chk(slot_idx == exp_slot[6:0], exp_req, "slot", slot_idx, exp_slot);
            chk(chan_id == exp_chan[7:0], exp_req, "chan", chan_id, exp_chan);
         end
      end
      sync = s;
      din  = d;
      cur  = (s && !m_unch) ? 0 : m_pos;
      live = m_unch || m_aligned || s;
      if (s && !m_unch) m_aligned = 1;
      framing = m_t1 && cur == 0;
      off = m_t1 ? cur - 1 : cur;
      m_shift = {m_shift[6:0], d};
      exp_v = live && !framing && (off % 8 == 7) && !m_err && m_count != 0;
      slot  = m_unch ? 0 : off / 8;
      if (m_unch) begin
         exp_chan = m_first;
         exp_req  = "R7";
      end else begin
         sp  = (m_count == 0) ? 1 : m_slots / m_count;
         idx = slot / sp;
         exp_req = m_t1 ? "R2" : "R4";
         if (idx >= m_count) begin
            idx = m_count - 1;
            exp_req = "R5";
         end
         exp_chan = (m_first + idx) % 256;
      end
      exp_slot = slot;
      exp_data = m_shift;
      m_pos = (cur == m_len - 1) ? 0 : cur + 1;
      @(negedge clk);
   endtask

   task automatic configure(input int md, input int first, input int cnt,
                            input string itag);
      rst_n = 0;
      sync = 0;
      din = 0;
      mode = md[2:0];
      first_chan = first[7:0];
      chan_count = cnt[7:0];
      repeat (3) @(negedge clk);
      m_unch  = (md == 4);
      m_t1    = (md == 0);
      m_slots = (md == 0) ? 24 : (md == 1) ? 32 : (md == 2) ? 64 : (md == 3) ? 128 : 0;
      m_len   = (md == 0) ? 193 : (md >= 1 && md <= 3) ? m_slots * 8 : 8;
      m_first = first;
      m_count = cnt;
      m_err   = (md > 4) || (m_unch && cnt > 1) || (!m_unch && cnt > m_slots);
      m_pos = 0;
      m_aligned = 0;
      m_shift = 0;
      exp_v = 0;
      idle_req = itag;
      chk(byte_valid == 0 && byte_data == 0 && slot_idx == 0 && chan_id == 0,
          "R11", "reset outputs", {byte_valid, byte_data}, 0);
      chk(cfg_err == m_err, "R8", "cfg_err", cfg_err, m_err);
      rst_n = 1;
   endtask

   task automatic run_frames(input int pre, input int frames);
      for (int i = 0; i < pre; i++) step(0, next_bit());
      for (int f = 0; f < frames; f++)
         for (int i = 0; i < m_len; i++) step(i == 0, next_bit());
      for (int i = 0; i < 3; i++) step(0, next_bit());
   endtask

   task automatic sweep(input int md, input int first, input int cnt, input string itag);
      configure(md, first, cnt, itag);
      run_frames(11, 2);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      checks++;
      fails++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      @(negedge clk);
      // R2 framing bit, R4 equal shares, R5 remainder, R1 frame lengths
      sweep(0, 2, 8, "R9");
      sweep(0, 40, 5, "R9");
      sweep(0, 7, 24, "R1");
      sweep(0, 9, 1, "R1");
      sweep(1, 100, 3, "R5");
      sweep(1, 250, 8, "R4");
      sweep(1, 0, 32, "R1");
      sweep(2, 17, 7, "R5");
      sweep(2, 64, 64, "R1");
      sweep(3, 1, 3, "R5");
      sweep(3, 0, 128, "R1");
      // R6 idle port
      sweep(0, 5, 0, "R6");
      sweep(3, 5, 0, "R6");
      // R8 error cases
      sweep(0, 3, 25, "R8");
      sweep(1, 3, 33, "R8");
      sweep(3, 3, 129, "R8");
      sweep(5, 3, 1, "R8");
      // R7 unchannelized, sync toggles are ignored
      configure(4, 200, 1, "R7");
      for (int i = 0; i < 400; i++) step(next_bit(), next_bit());
      configure(4, 200, 2, "R8");
      for (int i = 0; i < 64; i++) step(next_bit(), next_bit());
      // R10 sync arriving mid-frame realigns the slots
      configure(1, 30, 4, "R10");
      run_frames(0, 1);
      for (int i = 0; i < 101; i++) step(0, next_bit());
      run_frames(0, 2);
      configure(0, 60, 6, "R10");
      run_frames(5, 1);
      for (int i = 0; i < 77; i++) step(0, next_bit());
      run_frames(0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule